// File: doc/BRIEF.md
# Scaled System Timestamp Counter

This block keeps a system-wide timestamp for timer consumers on the same chip. A wide accumulator advances once per counter clock. Its upper 64 bits are the visible count, and the lower 24 bits hold a binary fraction. The visible count is always driven on a broadcast bus. There is no handshake and no back-pressure on that bus: consumers sample it whenever they need it. Because the increment is an 8.24 fixed-point value, the count can run at a fractional or multiple rate relative to the clock. When scaling is off, the count advances by exactly one per clock.

Software reaches the block over a 32-bit APB-style bus. The bus supports word access only and has no wait states. A write commits on the rising edge where select, `penable` and `pwrite` are all high. Read data is combinational during the setup and access phases. Two windows share the bus. The control window is selected by `ctl_sel` and holds the control, scale and count-load registers. The status window is selected by `sts_sel`; it is read-only and exposes only the count. Both windows also return fixed identification bytes.

Top module: `tstamp_counter`

## Requirements
- R1: After reset, the control register reads 0, the scale register reads 0x01000000 and the count is 0.
- R2: The control register at offset 0x000 stores bits [4:0] and reads them back: bit 0 enable, bit 1 debug-halt, bit 2 scale enable, bit 3 irq mask, bit 4 error disable. Bits [31:5] read as zero, and writes to them have no effect.
- R3: With enable = 1 and scale enable = 0, the count rises by exactly 1 on every clock, and carries propagate from the low 32 bits into the high 32 bits.
- R4: With enable = 0, the count holds its value. After the counter is enabled again, it continues from the held value.
- R5: With enable = 1 and scale enable = 1, every clock adds the 32-bit scale value to the accumulator. The visible count is the accumulator value shifted right by 24 bits. With scale enable = 0, the scale value has no effect.
- R6: A write to offset 0x008 replaces count bits [31:0], and a write to 0x00C replaces count bits [63:32]. The other half is unchanged and the 24 fraction bits are cleared. When a load and an increment fall in the same clock, the load wins.
- R7: The scale register can be read and written at both 0x010 and 0x0D0. Offset 0x0D4 reads as zero and ignores writes.
- R8: Offset 0x004 reads as zero. Offset 0x01C reads 0x00020001. Writes to either offset are ignored.
- R9: The status window reads count bits [31:0] at 0x000 and bits [63:32] at 0x004. Writes to the status window change nothing.
- R10: Word offsets 0xFD0 to 0xFFC in both windows return the bytes 04,00,00,00,xx,B0,0B,00,0D,F0,05,B1 in ascending address order. Here xx is BA in the control window and BB in the status window.
- R11: Reads of unmapped offsets return zero, and writes to unmapped offsets are ignored.
- R12: `count_out` always equals the count that the count registers read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sel | input | 1 | Select for the control window |
| sts_sel | input | 1 | Select for the status window |
| penable | input | 1 | Access phase of a bus transfer |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the selected window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when no read is selected |
| count_out | output | 64 | Broadcast visible count |

## Verification
Some behaviours are checked by assertions on every cycle:
- the count holds while the counter is off;
- the count advances by one per clock when unscaled;
- at most one half is loaded at a time, and a load wins over the increment;
- the zero-reading control bits and status register stay zero;
- the bus read of the count matches `count_out`.

Other behaviours can only be shown by the bench scenarios:
- fractional accumulation at scale factors of 0.5 and 2.5;
- clearing of the fraction on a load;
- carry across the 32-bit boundary;
- the aliases of the scale register;
- the identification bytes;
- writes that must be ignored.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int CNT_W   = 64;
  localparam int FRAC_W  = 24;
  localparam int STEP_W  = 32;
  localparam int WORD_W  = 32;
  localparam int ADDR_W  = 12;
  localparam int CTL_BITS = 5;
  localparam int CTL_EN  = 0;
  localparam int CTL_SCL = 2;

  localparam logic [STEP_W-1:0] UNIT_STEP = STEP_W'(1) << FRAC_W;

  localparam logic [ADDR_W-1:0] A_CTRL  = 12'h000;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h004;
  localparam logic [ADDR_W-1:0] A_CV    = 12'h008;
  localparam logic [ADDR_W-1:0] A_SCL   = 12'h010;
  localparam logic [ADDR_W-1:0] A_IDR   = 12'h01C;
  localparam logic [ADDR_W-1:0] A_SCL0  = 12'h0D0;
  localparam logic [ADDR_W-1:0] A_SCL1  = 12'h0D4;
  localparam logic [ADDR_W-1:0] S_CV    = 12'h000;

  localparam logic [WORD_W-1:0] IDR_VAL = 32'h0002_0001;

  function automatic logic [7:0] ident_byte(input logic [3:0] idx, input logic is_sts);
    case (idx)
      4'd0:    ident_byte = 8'h04;
      4'd4:    ident_byte = is_sts ? 8'hBB : 8'hBA;
      4'd5:    ident_byte = 8'hB0;
      4'd6:    ident_byte = 8'h0B;
      4'd8:    ident_byte = 8'h0D;
      4'd9:    ident_byte = 8'hF0;
      4'd10:   ident_byte = 8'h05;
      4'd11:   ident_byte = 8'hB1;
      default: ident_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/tsc_accum.sv
module tsc_accum #(
  parameter int CNT_W  = 64,
  parameter int FRAC_W = 24,
  parameter int STEP_W = 32,
  parameter int WORD_W = 32,
  localparam int ACC_W = CNT_W + FRAC_W,
  localparam int NHALF = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              scale_on,
  input  logic [STEP_W-1:0] step,
  input  logic [NHALF-1:0]  ld_sel,
  input  logic [WORD_W-1:0] ld_data,
  output logic [CNT_W-1:0]  count
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] inc;
  logic [CNT_W-1:0] loaded;

  always_comb inc = scale_on ? ACC_W'(step) : (ACC_W'(1) << FRAC_W);

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign loaded[h*WORD_W +: WORD_W] =
      ld_sel[h] ? ld_data : acc[FRAC_W + h*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           acc <= '0;
    else if (|ld_sel)     acc <= {loaded, {FRAC_W{1'b0}}};
    else if (run)         acc <= acc + inc;
  end

  assign count = acc[ACC_W-1:FRAC_W];

  assert_hold_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && ld_sel == '0) |=> $stable(count));
  assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !scale_on && ld_sel == '0) |=> count == $past(count) + 1'b1);
  assert_single_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_sel));
  assert_load_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sel[0] |=> (count[WORD_W-1:0] == $past(ld_data)) &&
                  (count[CNT_W-1:WORD_W] == $past(count[CNT_W-1:WORD_W])));
endmodule

// File: rtl/tsc_ctrl_regs.sv
module tsc_ctrl_regs
  import tsc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [CTL_BITS-1:0] ctl,
  output logic [STEP_W-1:0]   step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      step <= UNIT_STEP;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctl <= wdata[CTL_BITS-1:0];
      if (addr == A_SCL || addr == A_SCL0) step <= wdata;
    end
  end
endmodule

// File: rtl/tsc_rd_mux.sv
module tsc_rd_mux
  import tsc_pkg::*;
(
  input  logic                is_sts,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CTL_BITS-1:0] ctl,
  input  logic [STEP_W-1:0]   step,
  input  logic [CNT_W-1:0]    count,
  output logic [WORD_W-1:0]   rdata
);
  localparam int NHALF = CNT_W / WORD_W;
  logic            in_id;
  logic [3:0]      id_idx;
  logic [ADDR_W-1:0] cv_base;

  always_comb begin
    in_id   = (addr[ADDR_W-1:6] == '1) && (addr[5:4] != 2'b00) && (addr[1:0] == 2'b00);
    id_idx  = addr[5:2] - 4'd4;
    cv_base = is_sts ? S_CV : A_CV;
    rdata   = '0;
    if (in_id) rdata = WORD_W'(ident_byte(id_idx, is_sts));
    for (int h = 0; h < NHALF; h++)
      if (addr == cv_base + ADDR_W'(4*h)) rdata = count[h*WORD_W +: WORD_W];
    if (!is_sts) begin
      case (addr)
        A_CTRL:       rdata = WORD_W'(ctl);
        A_SCL, A_SCL0: rdata = step;
        A_IDR:        rdata = IDR_VAL;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/tstamp_counter.sv
module tstamp_counter
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_sel,
  input  logic              sts_sel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [WORD_W-1:0] pwdata,
  output logic [WORD_W-1:0] prdata,
  output logic [CNT_W-1:0]  count_out
);
  localparam int NHALF = CNT_W / WORD_W;

  logic                ctl_wr;
  logic [CTL_BITS-1:0] ctl;
  logic [STEP_W-1:0]   step;
  logic [NHALF-1:0]    ld_sel;
  logic [WORD_W-1:0]   mux_data;

  assign ctl_wr = ctl_sel && penable && pwrite;

  for (genvar h = 0; h < NHALF; h++) begin : g_ld
    assign ld_sel[h] = ctl_wr && (paddr == A_CV + ADDR_W'(4*h));
  end

  tsc_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .addr(paddr),
    .wdata(pwdata), .ctl(ctl), .step(step)
  );

  tsc_accum #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W), .WORD_W(WORD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run(ctl[CTL_EN]), .scale_on(ctl[CTL_SCL]),
    .step(step), .ld_sel(ld_sel), .ld_data(pwdata), .count(count_out)
  );

  tsc_rd_mux u_mux (
    .is_sts(!ctl_sel), .addr(paddr), .ctl(ctl), .step(step),
    .count(count_out), .rdata(mux_data)
  );

  assign prdata = ((ctl_sel || sts_sel) && !pwrite) ? mux_data : '0;

  assert_ctl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel && !pwrite && paddr == A_CTRL) |-> prdata[WORD_W-1:CTL_BITS] == '0);
  assert_stat_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel && !pwrite && paddr == A_STAT) |-> prdata == '0);
  assert_bus_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_sel && !pwrite && paddr == A_CV + 12'h4) |-> prdata == count_out[CNT_W-1:WORD_W]);
endmodule

// File: tb/tstamp_counter_bench.sv
module tstamp_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_sel = 1'b0, sts_sel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [63:0] count_out;

  int total = 0, bad = 0;
  longint unsigned cyc = 0;
  bit rd_active = 1'b0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tstamp_counter u_tstamp_counter (
    .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .sts_sel(sts_sel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .count_out(count_out)
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data during each read access phase
  always @(negedge clk) begin
    if (rd_active) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL monitor actual=%h expected=<none>", prdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check64(t, 64'(prdata), 64'(e));
      end
    end
  end

  task automatic bus_wr(input bit sts, input logic [11:0] a, input logic [31:0] d,
                        output longint unsigned at);
    @(posedge clk); #1;
    ctl_sel = !sts; sts_sel = sts; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    ctl_sel = 1'b0; sts_sel = 1'b0; pwrite = 1'b0; penable = 1'b0;
    at = cyc;
  endtask

  task automatic wr(input bit sts, input logic [11:0] a, input logic [31:0] d);
    longint unsigned t;
    bus_wr(sts, a, d, t);
  endtask

  task automatic rd(input bit sts, input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    ctl_sel = !sts; sts_sel = sts; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1; rd_active = 1'b1;
    @(posedge clk); #1;
    ctl_sel = 1'b0; sts_sel = 1'b0; penable = 1'b0; rd_active = 1'b0;
  endtask

  task automatic rd_count(input logic [63:0] e, input string tag);
    rd(1'b0, 12'h008, e[31:0], tag);
    rd(1'b0, 12'h00C, e[63:32], tag);
    check64({tag, " count_out R12"}, count_out, e);
  endtask

  task automatic load(input logic [63:0] v);
    wr(1'b0, 12'h00C, v[63:32]);
    wr(1'b0, 12'h008, v[31:0]);
  endtask

  // enable with given control value, wait, disable; returns clocks counted
  task automatic run_for(input logic [31:0] ctlv, input int n, output longint unsigned ticks);
    longint unsigned t0, t1;
    bus_wr(1'b0, 12'h000, ctlv, t0);
    repeat (n) @(posedge clk);
    bus_wr(1'b0, 12'h000, 32'h0, t1);
    ticks = t1 - t0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint unsigned n, tw, td;
    logic [63:0] e;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1 reset values
    rd(1'b0, 12'h000, 32'h0, "R1 ctl");
    rd(1'b0, 12'h010, 32'h0100_0000, "R1 scale");
    rd_count(64'h0, "R1 count");
    // R2 control bits
    wr(1'b0, 12'h000, 32'hFFFF_FFFF);
    rd(1'b0, 12'h000, 32'h1F, "R2 all ones");
    wr(1'b0, 12'h000, 32'h0000_001A);
    rd(1'b0, 12'h000, 32'h1A, "R2 pattern");
    wr(1'b0, 12'h000, 32'h0);
    // R6 half loads
    load(64'h0123_4567_89AB_CDEF);
    rd_count(64'h0123_4567_89AB_CDEF, "R6 load");
    wr(1'b0, 12'h008, 32'h1111_1111);
    rd_count(64'h0123_4567_1111_1111, "R6 low only");
    wr(1'b0, 12'h00C, 32'h2222_2222);
    rd_count(64'h2222_2222_1111_1111, "R6 high only");
    // R9 status window
    rd(1'b1, 12'h000, 32'h1111_1111, "R9 sts low");
    rd(1'b1, 12'h004, 32'h2222_2222, "R9 sts high");
    wr(1'b1, 12'h000, 32'hDEAD_BEEF);
    wr(1'b1, 12'h004, 32'hDEAD_BEEF);
    rd_count(64'h2222_2222_1111_1111, "R9 sts write ignored");
    // R3 unit stepping with carry
    load(64'h0000_0005_FFFF_FFF0);
    run_for(32'h1, 30, n);
    e = 64'h0000_0005_FFFF_FFF0 + n;
    rd_count(e, "R3 carry");
    // R4 hold and resume
    repeat (20) @(posedge clk);
    rd_count(e, "R4 hold");
    run_for(32'h1, 10, n);
    e = e + n;
    rd_count(e, "R4 resume");
    // R7 alias and R5 scaled 0.5
    wr(1'b0, 12'h0D0, 32'h0080_0000);
    rd(1'b0, 12'h010, 32'h0080_0000, "R7 alias read");
    load(64'h0);
    run_for(32'h5, 40, n);
    e = (n * 64'h0080_0000) >> 24;
    rd_count(e, "R5 half rate");
    // R6 fraction cleared on load
    wr(1'b0, 12'h008, 32'h0);
    run_for(32'h5, 40, n);
    e = (n * 64'h0080_0000) >> 24;
    rd_count(e, "R6 frac cleared");
    // R5 rate 2.5
    wr(1'b0, 12'h010, 32'h0280_0000);
    rd(1'b0, 12'h0D0, 32'h0280_0000, "R7 alias read back");
    load(64'h0);
    run_for(32'h5, 25, n);
    e = (n * 64'h0280_0000) >> 24;
    rd_count(e, "R5 rate 2.5");
    // R5 scale ignored when scaling off
    load(64'h0);
    run_for(32'h1, 25, n);
    rd_count(64'(n), "R5 scale off");
    // R6 load priority over increment
    load(64'h0);
    wr(1'b0, 12'h000, 32'h1);
    bus_wr(1'b0, 12'h008, 32'h0000_1000, tw);
    bus_wr(1'b0, 12'h000, 32'h0, td);
    rd_count(64'h1000 + (td - tw), "R6 load priority");
    // R7 second scale register
    wr(1'b0, 12'h0D4, 32'hDEAD_BEEF);
    rd(1'b0, 12'h0D4, 32'h0, "R7 scl1 zero");
    rd(1'b0, 12'h010, 32'h0280_0000, "R7 scl1 write ignored");
    // R8 status and ID
    wr(1'b0, 12'h004, 32'hFFFF_FFFF);
    wr(1'b0, 12'h01C, 32'hFFFF_FFFF);
    rd(1'b0, 12'h004, 32'h0, "R8 stat");
    rd(1'b0, 12'h01C, 32'h0002_0001, "R8 idr");
    // R10 identification bytes
    rd(1'b0, 12'hFD0, 32'h04, "R10 ctl fd0");
    rd(1'b0, 12'hFD4, 32'h00, "R10 ctl fd4");
    rd(1'b0, 12'hFE0, 32'hBA, "R10 ctl fe0");
    rd(1'b0, 12'hFE4, 32'hB0, "R10 ctl fe4");
    rd(1'b0, 12'hFE8, 32'h0B, "R10 ctl fe8");
    rd(1'b0, 12'hFF0, 32'h0D, "R10 ctl ff0");
    rd(1'b0, 12'hFFC, 32'hB1, "R10 ctl ffc");
    rd(1'b1, 12'hFE0, 32'hBB, "R10 sts fe0");
    rd(1'b1, 12'hFF4, 32'hF0, "R10 sts ff4");
    rd(1'b1, 12'hFF8, 32'h05, "R10 sts ff8");
    // R11 unmapped
    rd(1'b0, 12'h020, 32'h0, "R11 ctl 020");
    rd(1'b0, 12'h0D8, 32'h0, "R11 ctl 0d8");
    rd(1'b1, 12'h008, 32'h0, "R11 sts 008");
    wr(1'b0, 12'h020, 32'hFFFF_FFFF);
    wr(1'b1, 12'h010, 32'hFFFF_FFFF);
    rd(1'b0, 12'h000, 32'h0, "R11 ctl untouched");
    rd(1'b0, 12'h010, 32'h0280_0000, "R11 scale untouched");
    rd_count(64'h1000 + (td - tw), "R11 count untouched");
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL monitor actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule